// File: doc/BRIEF.md
# Sector Single-Bit ECC Checker

This block builds a 24-bit Hamming-style check code over a data sector streamed in one byte per cycle. Each data bit has a 12-bit address: the byte position in the sector (9 bits) above the bit number within the byte (3 bits). The block keeps two 12-bit parity halves. The upper half covers the data bits whose address has a given bit set. The lower half covers the data bits whose address has that bit clear. Internally the halves sit in a 32-bit raw word with two 4-bit reserved gaps. The packed code drops the gaps and is bitwise inverted, so a fully erased sector (all 0xFF) carries the code 0xFFFFFF.

A check request compares the freshly computed code against a stored code. It returns a one-cycle verdict: clean, a single data bit that can be corrected, a single bit flipped inside the stored code, or uncorrectable. For a correctable error the verdict also gives the byte position and a one-hot bit mask. The caller applies the correction to its own buffer. Every request also clears the accumulator for the next sector. The code reported with a request serves as the code to store when writing.

Top module: `sector_ecc_check`

## Requirements
- R1: After reset `res_valid` is 0, and a request made before any byte reports `res_code` = 0xFFFFFF.
- R2: Let A be the address {position, bit}. The upper parity half is the XOR of A over every set data bit, and the lower half is the XOR of ~A. `res_code` = ~{upper, lower}, with the upper half in bits 23:12.
- R3: A full sector of 0xFF bytes gives `res_code` = 0xFFFFFF and checks clean against a stored 0xFFFFFF.
- R4: A byte presented with `in_valid` and `in_start` both high is taken as position 0, and all earlier accumulation is dropped. Each other valid byte takes the next position.
- R5: When `chk_req` is high, `res_valid` is 1 in the following cycle only. The result includes a byte accepted in the same cycle as the request. Afterwards the accumulator and the position are cleared.
- R6: Let diff = computed code XOR `chk_code`. A diff of 0 gives status 0 (clean), with `res_byte` = 0 and `res_mask` = 0.
- R7: If diff[23:12] XOR diff[11:0] = 0xFFF and diff[23:15] < SECTOR_BYTES, the status is 1 (data bit corrected), `res_byte` = diff[23:15] and `res_mask` = 1 << diff[14:12].
- R8: If the halves are complementary but diff[23:15] >= SECTOR_BYTES, the status is 3 (uncorrectable), with `res_byte` = 0 and `res_mask` = 0.
- R9: A diff with exactly one bit set gives status 2 (code bit error), with `res_byte` = 0 and `res_mask` = 0.
- R10: Any other nonzero diff gives status 3, with `res_byte` = 0 and `res_mask` = 0.
- R11: `res_code` carries the computed packed code of the sector that was just closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_start | input | 1 | Marks the first byte of a sector (used only with in_valid) |
| in_valid | input | 1 | Data byte present |
| in_byte | input | 8 | Data byte |
| chk_req | input | 1 | Close the sector and compare against chk_code |
| chk_code | input | 24 | Stored packed code |
| res_valid | output | 1 | Verdict valid (one cycle) |
| res_status | output | 2 | 0 clean, 1 data fixed, 2 code bit, 3 uncorrectable |
| res_byte | output | 9 | Byte position of the corrected bit |
| res_mask | output | 8 | One-hot mask of the corrected bit |
| res_code | output | 24 | Computed packed code |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle response to a request;
- the accumulator clear after a request;
- the position stepping;
- consistency between each status and the other result fields: a clean verdict echoes the stored code, a code-bit verdict differs from it in exactly one bit, and a correction carries a one-hot mask inside the sector.

The bench's scenarios, checked against a parity model written per address bit, are needed for the rest:
- that the parity values are correct;
- that the erased-sector code is right;
- that the exact corrected position is found at both ends of the sector;
- that the range limit applies on a shorter sector;
- that a byte arriving in the same cycle as the request is included.

// File: rtl/secc_pkg.sv
package secc_pkg;
  localparam int BIT_W  = 3;
  localparam int IDX_W  = 9;
  localparam int ADDR_W = IDX_W + BIT_W;
  localparam int CODE_W = 2 * ADDR_W;
  localparam int RAW_W  = 32;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_CODE_BIT = 2'd2,
    ST_UNCORR   = 2'd3
  } status_e;

  typedef struct packed {
    logic [ADDR_W-1:0] hi;
    logic [ADDR_W-1:0] lo;
  } par_t;

  typedef struct packed {
    status_e           status;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        mask;
  } verdict_t;

  // Fold one byte at position idx into the parity halves.
  function automatic par_t fold_byte(par_t p, logic [IDX_W-1:0] idx, logic [7:0] d);
    par_t r;
    logic [ADDR_W-1:0] a;
    r = p;
    for (int b = 0; b < 8; b++) begin
      a = {idx, BIT_W'(b)};
      if (d[b]) begin
        r.hi = r.hi ^ a;
        r.lo = r.lo ^ ~a;
      end
    end
    return r;
  endfunction

  // Gapped raw layout: hi in 27:16, lo in 11:0, reserved bits zero.
  function automatic logic [RAW_W-1:0] raw_word(par_t p);
    return {4'b0000, p.hi, 4'b0000, p.lo};
  endfunction

  function automatic logic [CODE_W-1:0] pack_code(logic [RAW_W-1:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  function automatic verdict_t judge(logic [CODE_W-1:0] diff, int unsigned limit);
    verdict_t v;
    v.status = ST_CLEAN;
    v.idx    = '0;
    v.mask   = '0;
    if (diff == '0) begin
      v.status = ST_CLEAN;
    end else if ((diff[CODE_W-1:ADDR_W] ^ diff[ADDR_W-1:0]) == {ADDR_W{1'b1}}) begin
      if (32'(diff[CODE_W-1:ADDR_W+BIT_W]) < limit) begin
        v.status = ST_DATA_FIX;
        v.idx    = diff[CODE_W-1:ADDR_W+BIT_W];
        v.mask   = 8'd1 << diff[ADDR_W+BIT_W-1:ADDR_W];
      end else begin
        v.status = ST_UNCORR;
      end
    end else if ((diff & (diff - 1'b1)) == '0) begin
      v.status = ST_CODE_BIT;
    end else begin
      v.status = ST_UNCORR;
    end
    return v;
  endfunction
endpackage

// File: rtl/secc_accum.sv
module secc_accum
  import secc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_start,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             clr,
  output par_t             par_next,
  output par_t             par_q,
  output logic [IDX_W-1:0] pos_q
);
  logic             restart;
  par_t             par_base;
  logic [IDX_W-1:0] pos_base;

  assign restart  = in_valid && in_start;
  assign par_base = restart ? '0 : par_q;
  assign pos_base = restart ? '0 : pos_q;

  always_comb begin
    par_next = par_q;
    if (in_valid) par_next = fold_byte(par_base, pos_base, in_byte);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q <= '0;
      pos_q <= '0;
    end else if (clr) begin
      par_q <= '0;
      pos_q <= '0;
    end else if (in_valid) begin
      par_q <= par_next;
      pos_q <= pos_base + 1'b1;
    end
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (par_q == '0 && pos_q == '0));
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && !clr) |=> pos_q == IDX_W'(1));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_start && !clr) |=> pos_q == IDX_W'($past(pos_q) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(par_q) && $stable(pos_q));
endmodule

// File: rtl/secc_judge.sv
module secc_judge
  import secc_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc,
  input  logic [CODE_W-1:0] stored,
  output logic [CODE_W-1:0] diff,
  output verdict_t          verdict
);
  assign diff    = calc ^ stored;
  assign verdict = judge(diff, SECTOR_BYTES);
endmodule

// File: rtl/sector_ecc_check.sv
module sector_ecc_check
  import secc_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_start,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              chk_req,
  input  logic [23:0]       chk_code,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [8:0]        res_byte,
  output logic [7:0]        res_mask,
  output logic [23:0]       res_code
);
  par_t              fold_par;
  par_t              held_par;
  logic [IDX_W-1:0]  pos_w;
  logic [RAW_W-1:0]  calc_raw;
  logic [CODE_W-1:0] calc_code;
  logic [CODE_W-1:0] diff_w;
  verdict_t          verdict;

  secc_accum u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_start (in_start),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .clr      (chk_req),
    .par_next (fold_par),
    .par_q    (held_par),
    .pos_q    (pos_w)
  );

  assign calc_raw  = raw_word(fold_par);
  assign calc_code = pack_code(calc_raw);

  secc_judge #(.SECTOR_BYTES(SECTOR_BYTES)) u_judge (
    .calc    (calc_code),
    .stored  (chk_code),
    .diff    (diff_w),
    .verdict (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= ST_CLEAN;
      res_byte   <= '0;
      res_mask   <= '0;
      res_code   <= '1;
    end else begin
      res_valid <= chk_req;
      if (chk_req) begin
        res_status <= verdict.status;
        res_byte   <= verdict.idx;
        res_mask   <= verdict.mask;
        res_code   <= calc_code;
      end
    end
  end

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> res_valid);
  assert_only_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(chk_req));
  assert_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == ST_CLEAN) |->
      (res_code == $past(chk_code) && res_byte == '0 && res_mask == '0));
  assert_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == ST_DATA_FIX) |->
      ($onehot(res_mask) && 32'(res_byte) < SECTOR_BYTES));
  assert_code_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == ST_CODE_BIT) |->
      ($countones(res_code ^ $past(chk_code)) == 1 && res_byte == '0 && res_mask == '0));
  assert_uncorr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == ST_UNCORR) |->
      (res_code != $past(chk_code) && res_byte == '0 && res_mask == '0));
endmodule

// File: tb/sector_ecc_check_test.sv
`timescale 1ns/1ps
module sector_ecc_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        chk_req = 1'b0;
  logic [23:0] chk_code = '0;
  logic        res_valid, s_valid;
  logic [1:0]  res_status, s_status;
  logic [8:0]  res_byte, s_byte;
  logic [7:0]  res_mask, s_mask;
  logic [23:0] res_code, s_code;

  int checks = 0;
  int errors = 0;
  logic [7:0] sec [512];

  always #4 clk = ~clk;

  sector_ecc_check uut (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_valid(in_valid),
    .in_byte(in_byte), .chk_req(chk_req), .chk_code(chk_code),
    .res_valid(res_valid), .res_status(res_status), .res_byte(res_byte),
    .res_mask(res_mask), .res_code(res_code));

  sector_ecc_check #(.SECTOR_BYTES(256)) uut_small (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_valid(in_valid),
    .in_byte(in_byte), .chk_req(chk_req), .chk_code(chk_code),
    .res_valid(s_valid), .res_status(s_status), .res_byte(s_byte),
    .res_mask(s_mask), .res_code(s_code));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model: each parity bit k is accumulated separately over all bit addresses.
  function automatic logic [23:0] model_code(int n);
    logic [11:0] up = '0;
    logic [11:0] dn = '0;
    for (int k = 0; k < 12; k++)
      for (int i = 0; i < n; i++)
        for (int b = 0; b < 8; b++)
          if (sec[i][b]) begin
            if (((i * 8 + b) >> k) & 1) up[k] = ~up[k];
            else dn[k] = ~dn[k];
          end
    return ~{up, dn};
  endfunction

  function automatic logic [23:0] flip_pattern(int idx, int bitn);
    logic [11:0] a = 12'(idx * 8 + bitn);
    return {a, ~a};
  endfunction

  task automatic fill(int seed);
    for (int i = 0; i < 512; i++) sec[i] = 8'((i * 73 + seed * 29 + (i >> 3)) ^ (i >> 1));
  endtask

  task automatic feed(int n, bit with_start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_start = with_start && (i == 0);
      in_byte  = sec[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
  endtask

  task automatic request(logic [23:0] stored);
    @(negedge clk);
    chk_req  = 1'b1;
    chk_code = stored;
    @(negedge clk);
    chk_req  = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "res_valid after reset", 32'(res_valid), 0);
    request(24'hFFFFFF);
    check("R1", "empty code", 32'(res_code), 32'hFFFFFF);
    check("R1", "empty status", 32'(res_status), 0);
  endtask

  task automatic t_erased;
    for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
    feed(512, 1'b1);
    request(24'hFFFFFF);
    check("R3", "erased code", 32'(res_code), 32'hFFFFFF);
    check("R3", "erased status", 32'(res_status), 0);
  endtask

  task automatic t_clean;
    logic [23:0] exp;
    fill(1);
    exp = model_code(512);
    feed(512, 1'b1);
    request(exp);
    check("R2", "parity code", 32'(res_code), 32'(exp));
    check("R6", "clean status", 32'(res_status), 0);
    check("R6", "clean byte/mask", {res_byte, res_mask}, 0);
    check("R11", "result valid", 32'(res_valid), 1);
  endtask

  task automatic t_fix(int idx, int bitn, int seed);
    logic [23:0] stored;
    fill(seed);
    stored = model_code(512);
    sec[idx][bitn] = ~sec[idx][bitn];
    feed(512, 1'b1);
    request(stored);
    check("R7", "fix status", 32'(res_status), 1);
    check("R7", "fix byte", 32'(res_byte), 32'(idx));
    check("R7", "fix mask", 32'(res_mask), 32'(1 << bitn));
    check("R11", "code of read data", 32'(res_code), 32'(model_code(512)));
  endtask

  task automatic t_code_bit(logic [23:0] single);
    logic [23:0] calc;
    fill(3);
    calc = model_code(512);
    feed(512, 1'b1);
    request(calc ^ single);
    check("R9", "code bit status", 32'(res_status), 2);
    check("R9", "code bit byte/mask", {res_byte, res_mask}, 0);
  endtask

  task automatic t_uncorr;
    logic [23:0] stored;
    fill(4);
    stored = model_code(512);
    sec[10][1]  = ~sec[10][1];
    sec[200][6] = ~sec[200][6];
    feed(512, 1'b1);
    request(stored);
    check("R10", "two data bits status", 32'(res_status), 3);
    check("R10", "two data bits byte/mask", {res_byte, res_mask}, 0);
    fill(4);
    feed(512, 1'b1);
    request(stored ^ 24'h000003);
    check("R10", "two code bits status", 32'(res_status), 3);
  endtask

  task automatic t_restart;
    logic [23:0] exp;
    fill(5);
    feed(100, 1'b1);
    fill(6);
    exp = model_code(512);
    feed(512, 1'b1);
    request(exp);
    check("R4", "restart status", 32'(res_status), 0);
    check("R4", "restart code", 32'(res_code), 32'(exp));
  endtask

  task automatic t_same_cycle;
    logic [23:0] exp;
    fill(7);
    exp = model_code(512);
    for (int i = 0; i < 511; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (i == 0);
      in_byte  = sec[i];
    end
    @(negedge clk);
    in_start = 1'b0;
    in_byte  = sec[511];
    chk_req  = 1'b1;
    chk_code = exp;
    @(negedge clk);
    in_valid = 1'b0;
    chk_req  = 1'b0;
    check("R5", "same-cycle byte included", 32'(res_code), 32'(exp));
    check("R5", "same-cycle status", 32'(res_status), 0);
    @(negedge clk);
    check("R5", "valid lasts one cycle", 32'(res_valid), 0);
    request(24'hFFFFFF);
    check("R5", "cleared after request", 32'(res_code), 32'hFFFFFF);
  endtask

  task automatic t_range;
    logic [23:0] calc;
    fill(8);
    calc = model_code(256);
    feed(256, 1'b1);
    request(calc ^ flip_pattern(400, 2));
    check("R8", "small sector out of range status", 32'(s_status), 3);
    check("R8", "small sector byte/mask", {s_byte, s_mask}, 0);
    check("R7", "full sector same diff fixes", 32'(res_status), 1);
    check("R7", "full sector byte", 32'(res_byte), 400);
    fill(9);
    calc = model_code(256);
    feed(256, 1'b1);
    request(calc ^ flip_pattern(255, 0));
    check("R8", "small sector last byte fixes", 32'(s_status), 1);
    check("R8", "small sector last byte index", 32'(s_byte), 255);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_erased();
    t_clean();
    t_fix(300, 5, 2);
    t_fix(0, 0, 10);
    t_fix(511, 7, 11);
    t_code_bit(24'h800000);
    t_code_bit(24'h000001);
    t_uncorr();
    t_restart();
    t_same_cycle();
    t_range();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule